// File: doc/BRIEF.md
# Host Command Port with Acknowledge Handshake

This block sits between an 8-bit call-setup processor and the control logic of a switch controller. The processor talks to it with a strobe, a select line (data versus command/status) and a read/write line. A command is a one-byte opcode. The block decodes it and then gathers the data bytes that belong to that opcode. Some opcodes start with a two-byte address. Once the command is complete, the block offers it to the internal logic as a single transfer.

A status register lets the host see progress. Its top bit is an acknowledge flag, which rises once the internal logic has taken the command. The host must poll this flag after every command before it sends the next one.

The block also runs the start-up sequence. After reset is released, a counter measures the internal initialisation window. Command bytes are ignored until that window ends. The reset-chain output stays high until a start command has been handed over.

The command output is a valid/ready stream. While `cmd_valid` is high and `cmd_ready` is low, the code, address, data and byte count hold steady. A transfer takes place on any clock edge where both are high. After a transfer the block presents nothing new until the host writes another full command, so back-pressure only delays the acknowledge.

Top module: `mgr_cmd_port`

## Requirements
- R1: The strobe, select, read/write and data pins pass through two synchroniser flops. A write takes effect at the detected rising edge of the strobe while read/write is low. Select low marks a command byte and select high marks a data byte.
- R2: `hst_oe` is high exactly while read/write is high and the strobe is low, and it drops as the strobe rises. With select low, `hst_dout` shows the status register. With select high, it shows in bits 3:0 the number of data bytes still expected.
- R3: The status register uses four bits: bit 7 acknowledge, bit 6 initialisation complete, bit 5 opcode rejected, bit 4 collecting data bytes. Bits 3:0 read zero.
- R4: Status bit 6 sets on the 8191st clock edge after reset is released (parameter `INIT_CYCLES`). Before that, every host write is ignored.
- R5: Each accepted opcode carries a fixed number of data bytes after any address: 0x03 two, 0x07 none, 0x08 two, 0x09 four, 0x0A two, 0x0B one, 0x0C none, 0x0D two, 0x0E three.
- R6: Opcodes 0x03, 0x09 and 0x0D take a 16-bit address before their data. The first byte is address bits 15:8 and the second is bits 7:0. Data byte i goes to `cmd_data[8i+7:8i]`. Unused data bytes, and the address of opcodes without one, read zero.
- R7: Any other opcode sets status bit 5, issues no command and leaves the acknowledge low. The next command byte clears bit 5.
- R8: `cmd_valid` stays high with a stable payload until `cmd_ready` is high. Each full command produces exactly one transfer.
- R9: The acknowledge bit goes high on the clock edge after the transfer. Any accepted command byte write clears it.
- R10: `rst_out` goes high as soon as `rst_in` is high. It stays high until a transfer of opcode 0x0C, and then stays low until the next reset.
- R11: A data byte written outside collection is ignored. A command byte written during collection abandons the partial command and starts a new one. A command byte written while a command waits for `cmd_ready` is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_in | input | 1 | Asynchronous reset, active high |
| hst_strb | input | 1 | Host strobe; write on rising edge, read enable while low |
| hst_sel | input | 1 | 1 = data register, 0 = command/status register |
| hst_rnw | input | 1 | 1 = read, 0 = write |
| hst_din | input | 8 | Host bus, inbound |
| hst_dout | output | 8 | Host bus, outbound |
| hst_oe | output | 1 | Drive enable for the host bus |
| cmd_valid | output | 1 | Complete command offered |
| cmd_ready | input | 1 | Internal logic takes the command |
| cmd_code | output | 8 | Opcode |
| cmd_addr | output | 16 | Address field |
| cmd_data | output | 32 | Data bytes, byte 0 in bits 7:0 |
| cmd_nbytes | output | 3 | Number of valid data bytes |
| rst_out | output | 1 | Reset-chain output |

## Verification
The assertions assume the host follows the synchroniser timing. Select, read/write and data must be steady for at least two clocks before the strobe rises and must stay steady until the rising edge has crossed the synchroniser. Each strobe phase must also last at least two clocks. The bench's write task places the strobe falling edge two clocks after setting up the bus, raises the strobe two clocks later, and holds the bus for six clocks afterwards. Read cycles change only select and the strobe while read/write stays high.

// File: rtl/mgr_pkg.sv
package mgr_pkg;

  typedef enum logic [7:0] {
    OP_SLINK  = 8'h03,
    OP_STATUS = 8'h07,
    OP_SWCFG  = 8'h08,
    OP_SETUP  = 8'h09,
    OP_INIT   = 8'h0A,
    OP_SELECT = 8'h0B,
    OP_START  = 8'h0C,
    OP_CBR    = 8'h0D,
    OP_PARAM  = 8'h0E
  } op_e;

  localparam int ST_ACK  = 7;
  localparam int ST_INIT = 6;
  localparam int ST_REJ  = 5;
  localparam int ST_BUSY = 4;

  function automatic logic op_known(input logic [7:0] c);
    case (c)
      OP_SLINK, OP_STATUS, OP_SWCFG, OP_SETUP, OP_INIT,
      OP_SELECT, OP_START, OP_CBR, OP_PARAM: op_known = 1'b1;
      default: op_known = 1'b0;
    endcase
  endfunction

  function automatic logic op_has_addr(input logic [7:0] c);
    case (c)
      OP_SLINK, OP_SETUP, OP_CBR: op_has_addr = 1'b1;
      default: op_has_addr = 1'b0;
    endcase
  endfunction

  function automatic logic [2:0] op_data_bytes(input logic [7:0] c);
    case (c)
      OP_SLINK:  op_data_bytes = 3'd2;
      OP_SWCFG:  op_data_bytes = 3'd2;
      OP_SETUP:  op_data_bytes = 3'd4;
      OP_INIT:   op_data_bytes = 3'd2;
      OP_SELECT: op_data_bytes = 3'd1;
      OP_CBR:    op_data_bytes = 3'd2;
      OP_PARAM:  op_data_bytes = 3'd3;
      default:   op_data_bytes = 3'd0;
    endcase
  endfunction

endpackage

// File: rtl/mgr_sync.sv
module mgr_sync #(
  parameter int W = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage [STAGES];

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or posedge rst) begin
          if (rst) stage[0] <= RST_VAL;
          else     stage[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk or posedge rst) begin
          if (rst) stage[g] <= RST_VAL;
          else     stage[g] <= stage[g-1];
        end
      end
    end
  endgenerate

  assign q = stage[STAGES-1];
endmodule

// File: rtl/mgr_init_seq.sv
module mgr_init_seq #(
  parameter int INIT_CYCLES = 8191
) (
  input  logic clk,
  input  logic rst,
  input  logic start_fire,
  output logic init_done,
  output logic rst_out
);
  localparam int CNT_W = $clog2(INIT_CYCLES + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(INIT_CYCLES - 1);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      cnt       <= '0;
      init_done <= 1'b0;
    end else if (!init_done) begin
      if (cnt == LAST) init_done <= 1'b1;
      else             cnt <= cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or posedge rst) begin
    if (rst)             rst_out <= 1'b1;
    else if (start_fire) rst_out <= 1'b0;
  end

  AST_RSTOUT_HOLD: assert property (@(posedge clk) disable iff (rst)
    rst_out && !start_fire |=> rst_out);  // R10
  AST_RSTOUT_STAYS_LOW: assert property (@(posedge clk) disable iff (rst)
    !rst_out |=> !rst_out);  // R10
  AST_INIT_STICKY: assert property (@(posedge clk) disable iff (rst)
    init_done |=> init_done);  // R4
endmodule

// File: rtl/mgr_cmd_collect.sv
module mgr_cmd_collect
  import mgr_pkg::*;
#(
  parameter int MAX_DATA = 4
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        enable,
  input  logic                        wr_evt,
  input  logic                        wr_sel,
  input  logic [7:0]                  wr_byte,
  input  logic                        cmd_ready,
  output logic                        cmd_valid,
  output logic [7:0]                  cmd_code,
  output logic [15:0]                 cmd_addr,
  output logic [MAX_DATA*8-1:0]       cmd_data,
  output logic [$clog2(MAX_DATA+1)-1:0] cmd_nbytes,
  output logic                        ack,
  output logic                        reject,
  output logic                        busy,
  output logic [$clog2(MAX_DATA+3)-1:0] remaining
);
  localparam int POS_W = $clog2(MAX_DATA + 3);
  localparam int NB_W  = $clog2(MAX_DATA + 1);

  typedef enum logic [1:0] {S_IDLE, S_COLLECT, S_ISSUE} state_e;

  state_e           state;
  logic [POS_W-1:0] pos;
  logic [POS_W-1:0] total;
  logic             has_addr_r;
  logic [POS_W-1:0] dpos;
  logic             xfer;
  logic [2:0]       new_len;
  logic [POS_W-1:0] new_total;

  assign new_len   = op_data_bytes(wr_byte);
  assign new_total = POS_W'(new_len) + (op_has_addr(wr_byte) ? POS_W'(2) : POS_W'(0));
  assign dpos      = pos - (has_addr_r ? POS_W'(2) : POS_W'(0));
  assign cmd_valid = (state == S_ISSUE);
  assign xfer      = cmd_valid && cmd_ready;
  assign busy      = (state == S_COLLECT);
  assign remaining = busy ? (total - pos) : '0;

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      state      <= S_IDLE;
      pos        <= '0;
      total      <= '0;
      has_addr_r <= 1'b0;
      cmd_code   <= '0;
      cmd_addr   <= '0;
      cmd_data   <= '0;
      cmd_nbytes <= '0;
      ack        <= 1'b0;
      reject     <= 1'b0;
    end else begin
      case (state)
        S_ISSUE: begin
          if (cmd_ready) begin
            state <= S_IDLE;
            ack   <= 1'b1;
          end
        end
        default: begin
          if (enable && wr_evt && !wr_sel) begin
            ack <= 1'b0;
            if (op_known(wr_byte)) begin
              reject     <= 1'b0;
              cmd_code   <= wr_byte;
              cmd_addr   <= '0;
              cmd_data   <= '0;
              cmd_nbytes <= NB_W'(new_len);
              has_addr_r <= op_has_addr(wr_byte);
              total      <= new_total;
              pos        <= '0;
              state      <= (new_total == '0) ? S_ISSUE : S_COLLECT;
            end else begin
              reject <= 1'b1;
              state  <= S_IDLE;
            end
          end else if (enable && wr_evt && wr_sel && state == S_COLLECT) begin
            if (has_addr_r && pos == '0) begin
              cmd_addr[15:8] <= wr_byte;
            end else if (has_addr_r && pos == POS_W'(1)) begin
              cmd_addr[7:0] <= wr_byte;
            end else begin
              for (int k = 0; k < MAX_DATA; k++) begin
                if (dpos == POS_W'(k)) cmd_data[k*8 +: 8] <= wr_byte;
              end
            end
            pos <= pos + 1'b1;
            if (pos == total - 1'b1) state <= S_ISSUE;
          end
        end
      endcase
    end
  end

  AST_VALID_HOLD: assert property (@(posedge clk) disable iff (rst)
    cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_code) && $stable(cmd_addr)
                                && $stable(cmd_data) && $stable(cmd_nbytes));  // R8
  AST_ACK_AFTER_XFER: assert property (@(posedge clk) disable iff (rst)
    xfer |=> ack && !cmd_valid);  // R9
  AST_NO_CMD_BEFORE_INIT: assert property (@(posedge clk) disable iff (rst)
    !enable |-> !cmd_valid && !busy);  // R4
  AST_REJECT_QUIET: assert property (@(posedge clk) disable iff (rst)
    reject |-> !cmd_valid && !ack);  // R7
  AST_KNOWN_ISSUED: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |-> op_known(cmd_code));  // R5
  AST_ACK_LOW_PENDING: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid || busy) |-> !ack);  // R9
endmodule

// File: rtl/mgr_cmd_port.sv
module mgr_cmd_port
  import mgr_pkg::*;
#(
  parameter int INIT_CYCLES = 8191,
  parameter int SYNC_STAGES = 2,
  parameter int MAX_DATA    = 4
) (
  input  logic                          clk,
  input  logic                          rst_in,
  input  logic                          hst_strb,
  input  logic                          hst_sel,
  input  logic                          hst_rnw,
  input  logic [7:0]                    hst_din,
  output logic [7:0]                    hst_dout,
  output logic                          hst_oe,
  output logic                          cmd_valid,
  input  logic                          cmd_ready,
  output logic [7:0]                    cmd_code,
  output logic [15:0]                   cmd_addr,
  output logic [MAX_DATA*8-1:0]         cmd_data,
  output logic [$clog2(MAX_DATA+1)-1:0] cmd_nbytes,
  output logic                          rst_out
);
  localparam int POS_W  = $clog2(MAX_DATA + 3);
  localparam int SYNC_W = 11;

  logic [SYNC_W-1:0] s_bus;
  logic              s_strb, s_sel, s_rnw, strb_prev;
  logic [7:0]        s_din;
  logic              wr_evt;
  logic              init_done, ack, reject, busy, start_fire;
  logic [POS_W-1:0]  remaining;
  logic [7:0]        status;

  mgr_sync #(.W(SYNC_W), .STAGES(SYNC_STAGES), .RST_VAL(11'b101_0000_0000)) i_sync (
    .clk (clk),
    .rst (rst_in),
    .d   ({hst_strb, hst_sel, hst_rnw, hst_din}),
    .q   (s_bus)
  );

  assign {s_strb, s_sel, s_rnw, s_din} = s_bus;

  always_ff @(posedge clk or posedge rst_in) begin
    if (rst_in) strb_prev <= 1'b1;
    else        strb_prev <= s_strb;
  end

  assign wr_evt = s_strb && !strb_prev && !s_rnw;

  mgr_cmd_collect #(.MAX_DATA(MAX_DATA)) i_collect (
    .clk        (clk),
    .rst        (rst_in),
    .enable     (init_done),
    .wr_evt     (wr_evt),
    .wr_sel     (s_sel),
    .wr_byte    (s_din),
    .cmd_ready  (cmd_ready),
    .cmd_valid  (cmd_valid),
    .cmd_code   (cmd_code),
    .cmd_addr   (cmd_addr),
    .cmd_data   (cmd_data),
    .cmd_nbytes (cmd_nbytes),
    .ack        (ack),
    .reject     (reject),
    .busy       (busy),
    .remaining  (remaining)
  );

  assign start_fire = cmd_valid && cmd_ready && (cmd_code == OP_START);

  mgr_init_seq #(.INIT_CYCLES(INIT_CYCLES)) i_init (
    .clk        (clk),
    .rst        (rst_in),
    .start_fire (start_fire),
    .init_done  (init_done),
    .rst_out    (rst_out)
  );

  always_comb begin
    status          = '0;
    status[ST_ACK]  = ack;
    status[ST_INIT] = init_done;
    status[ST_REJ]  = reject;
    status[ST_BUSY] = busy;
  end

  assign hst_oe   = hst_rnw && !hst_strb;
  assign hst_dout = hst_sel ? 8'(remaining) : status;

  AST_ONE_FLAG: assert property (@(posedge clk) disable iff (rst_in)
    $countones({ack, reject, busy, cmd_valid}) <= 1);  // R3
  AST_WRITE_NEEDS_EDGE: assert property (@(posedge clk) disable iff (rst_in)
    wr_evt |-> $rose(s_strb));  // R1
endmodule

// File: tb/test_mgr_cmd_port.sv
module test_mgr_cmd_port;
  logic        clk = 1'b0;
  logic        rst_in = 1'b1;
  logic        hst_strb = 1'b1, hst_sel = 1'b0, hst_rnw = 1'b1;
  logic [7:0]  hst_din = '0;
  logic [7:0]  hst_dout;
  logic        hst_oe, cmd_valid, rst_out;
  logic        cmd_ready = 1'b1;
  logic [7:0]  cmd_code;
  logic [15:0] cmd_addr;
  logic [31:0] cmd_data;
  logic [2:0]  cmd_nbytes;

  int nchk = 0, nerr = 0;
  bit finished = 0;

  typedef struct { logic [7:0] code; logic [15:0] addr; logic [31:0] data; logic [2:0] n; } item_t;
  item_t exp_q[$];

  always #5 clk = ~clk;

  mgr_cmd_port i_mgr_cmd_port (
    .clk(clk), .rst_in(rst_in), .hst_strb(hst_strb), .hst_sel(hst_sel),
    .hst_rnw(hst_rnw), .hst_din(hst_din), .hst_dout(hst_dout), .hst_oe(hst_oe),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_code(cmd_code),
    .cmd_addr(cmd_addr), .cmd_data(cmd_data), .cmd_nbytes(cmd_nbytes), .rst_out(rst_out)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic host_wr(input logic sel, input logic [7:0] b);
    @(posedge clk); #1 hst_rnw = 1'b0; hst_sel = sel; hst_din = b;
    repeat (2) @(posedge clk); #1 hst_strb = 1'b0;
    #1 check(hst_oe == 1'b0, "R2 no drive in write", hst_oe, 0);
    repeat (2) @(posedge clk); #1 hst_strb = 1'b1;
    repeat (6) @(posedge clk); #1 hst_rnw = 1'b1;
  endtask

  task automatic host_rd(input logic sel, input logic [7:0] exp, input string req);
    logic [7:0] v;
    @(posedge clk); #1 hst_sel = sel; hst_strb = 1'b0;
    #2 v = hst_dout;
    check(hst_oe == 1'b1, "R2 drive while strobe low", hst_oe, 1);
    check(v == exp, req, v, exp);
    hst_strb = 1'b1;
    #1 check(hst_oe == 1'b0, "R2 release on strobe high", hst_oe, 0);
  endtask

  task automatic expect_cmd(input logic [7:0] c, input logic [15:0] a, input logic [31:0] d, input logic [2:0] n);
    item_t it;
    it.code = c; it.addr = a; it.data = d; it.n = n;
    exp_q.push_back(it);
  endtask

  // scoreboard monitor: R6 R8
  always @(negedge clk) begin
    if (!rst_in && cmd_valid && cmd_ready) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R8 unexpected command", {56'd0, cmd_code}, 0);
      end else begin
        item_t e;
        e = exp_q.pop_front();
        check(cmd_code == e.code, "R5 code", cmd_code, e.code);
        check(cmd_addr == e.addr, "R6 address", cmd_addr, e.addr);
        check(cmd_data == e.data, "R6 data", cmd_data, e.data);
        check(cmd_nbytes == e.n, "R5 byte count", cmd_nbytes, e.n);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nerr++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end

  initial begin
    repeat (10) @(posedge clk);
    #1 check(rst_out == 1'b1, "R10 rst_out in reset", rst_out, 1);
    host_rd(1'b0, 8'h00, "R3 status in reset");
    @(posedge clk); #1 rst_in = 1'b0;
    // R4: writes before init complete are ignored
    host_wr(1'b0, 8'h07);
    host_rd(1'b0, 8'h00, "R4 pre-init write ignored");
    repeat (8100 - 30) @(posedge clk);
    host_rd(1'b0, 8'h00, "R4 init not yet complete");
    repeat (150) @(posedge clk);
    host_rd(1'b0, 8'h40, "R4 init complete");
    check(rst_out == 1'b1, "R10 rst_out held before start", rst_out, 1);
    // R7 unknown opcode
    host_wr(1'b0, 8'h05);
    host_rd(1'b0, 8'h60, "R7 reject flag");
    // R5 R9 zero-byte command
    expect_cmd(8'h07, 16'h0, 32'h0, 3'd0);
    host_wr(1'b0, 8'h07);
    host_rd(1'b0, 8'hC0, "R9 ack after status command, R7 reject cleared");
    // R11 stray data byte
    host_wr(1'b1, 8'h33);
    host_rd(1'b1, 8'h00, "R11 stray data ignored");
    host_rd(1'b0, 8'hC0, "R11 status unchanged");
    // R9 ack clear, R11 restart
    host_wr(1'b0, 8'h09);
    host_rd(1'b0, 8'h50, "R9 ack cleared by command byte");
    host_rd(1'b1, 8'h06, "R2 remaining for setup");
    host_wr(1'b1, 8'h12);
    host_wr(1'b1, 8'h34);
    host_rd(1'b1, 8'h04, "R1 data bytes counted");
    expect_cmd(8'h0B, 16'h0, 32'h5A, 3'd1);
    host_wr(1'b0, 8'h0B);
    host_rd(1'b1, 8'h01, "R11 restart on new opcode");
    host_wr(1'b1, 8'h5A);
    host_rd(1'b0, 8'hC0, "R9 ack after select");
    // R6 full setup command
    expect_cmd(8'h09, 16'hBEEF, 32'h44332211, 3'd4);
    foreach (i_bytes[k]) host_wr(k == 0 ? 1'b0 : 1'b1, i_bytes[k]);
    host_rd(1'b0, 8'hC0, "R6 setup acknowledged");
    // R8 back-pressure, R11 ignore while pending
    cmd_ready = 1'b0;
    expect_cmd(8'h0D, 16'h0102, 32'h0000A5C3, 3'd2);
    host_wr(1'b0, 8'h0D); host_wr(1'b1, 8'h01); host_wr(1'b1, 8'h02);
    host_wr(1'b1, 8'hC3); host_wr(1'b1, 8'hA5);
    host_wr(1'b0, 8'h07);
    repeat (5) @(posedge clk);
    #1 check(cmd_valid == 1'b1, "R8 valid held", cmd_valid, 1);
    check(cmd_code == 8'h0D, "R8 code held", cmd_code, 8'h0D);
    host_rd(1'b0, 8'h40, "R9 no ack while pending");
    @(posedge clk); #1 cmd_ready = 1'b1;
    repeat (3) @(posedge clk);
    host_rd(1'b0, 8'hC0, "R8 ack after release");
    // other opcodes
    expect_cmd(8'h0E, 16'h0, 32'h00030201, 3'd3);
    host_wr(1'b0, 8'h0E); host_wr(1'b1, 8'h01); host_wr(1'b1, 8'h02); host_wr(1'b1, 8'h03);
    expect_cmd(8'h03, 16'h8001, 32'h0000FF7E, 3'd2);
    host_wr(1'b0, 8'h03); host_wr(1'b1, 8'h80); host_wr(1'b1, 8'h01);
    host_wr(1'b1, 8'h7E); host_wr(1'b1, 8'hFF);
    host_rd(1'b0, 8'hC0, "R5 address command acknowledged");
    check(rst_out == 1'b1, "R10 rst_out held", rst_out, 1);
    // R10 start
    expect_cmd(8'h0C, 16'h0, 32'h0, 3'd0);
    host_wr(1'b0, 8'h0C);
    #1 check(rst_out == 1'b0, "R10 rst_out low after start", rst_out, 0);
    expect_cmd(8'h0A, 16'h0, 32'h00002211, 3'd2);
    host_wr(1'b0, 8'h0A); host_wr(1'b1, 8'h11); host_wr(1'b1, 8'h22);
    #1 check(rst_out == 1'b0, "R10 rst_out stays low", rst_out, 0);
    @(posedge clk); #1 rst_in = 1'b1;
    #1 check(rst_out == 1'b1, "R10 rst_out on reset", rst_out, 1);
    host_rd(1'b0, 8'h00, "R3 status cleared by reset");
    check(exp_q.size() == 0, "R8 all commands seen", exp_q.size(), 0);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  logic [7:0] i_bytes [7] = '{8'h09, 8'hBE, 8'hEF, 8'h11, 8'h22, 8'h33, 8'h44};
endmodule